// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by walking a radix page table held in memory. A request carries the virtual address, the kind of access (instruction fetch, load or store) and the privilege it runs at. Side inputs select the root table page, the number of levels, the index width per level, whether entries are four or eight bytes wide, and two status flags. The first flag lets supervisor code reach user pages. The second lets loads read pages that are only executable. The walker issues one entry read per level and waits for each answer. The answer includes a protection verdict on the entry address. The walk ends with a single result: a physical address, a page fault or an access fault. The result carries the access type of the request.

Accessed and dirty bits are never written back. A leaf entry that lacks them faults. Superpage leaves are returned at page granularity, with the low virtual page bits merged into the physical page number. With zero levels the walker is transparent and reads nothing.

Both the request and the result are valid/ready streams, and so is the entry read. A request is taken only while the walker is idle, so one walk is in flight at a time. A result is held, with every field stable, until the consumer raises `res_ready`. An entry read is held, with its address stable, until `mem_req_ready`.

Top module: `pt_walker`

## Requirements
- R1: With `cfg_levels` = 0 the result is status 0 (ok) with `res_paddr` equal to the virtual address, zero-extended, and no entry read is issued.
- R2: Let `vb` = 12 + levels × index bits. If `vb` does not exceed XLEN, every virtual address bit from `vb`-1 upward must equal bit `vb`-1. Otherwise the walk ends in status 1 (page fault) with no entry read.
- R3: The root base is `cfg_root_ppn` shifted left by 12. At level L (starting at levels-1), the index is the virtual address bits from position 12 + L × index bits, masked to the index width. The entry address is base + index × 8 when `cfg_pte8` = 1, and base + index × 4 when it is 0. For 4-byte entries only the low 32 data bits count.
- R4: An entry read answered with `mem_rsp_err` = 1 or `mem_rsp_pmp_ok` = 0 ends the walk in status 2 (access fault).
- R5: An entry with V (bit 0) set and R, W and X (bits 1, 2, 3) clear is a pointer. The base for the next level becomes its page number (bits from 10 upward) shifted left by 12. A pointer at level 0 ends in a page fault.
- R6: Privilege code 1 is supervisor. A leaf with U (bit 4) set faults for a supervisor fetch, and for a supervisor load or store when `cfg_sum` = 0. A leaf with U clear faults whenever the privilege is not supervisor.
- R7: A leaf with V clear, or with W set and R clear, gives a page fault.
- R8: Access type 0 is fetch, 1 is load and 2 is store. A fetch needs X. A load needs R, or X when `cfg_mxr` = 1. A store needs both R and W. A missing permission gives a page fault.
- R9: A leaf found at level L > 0 whose page number has any of its low L × index bits set gives a page fault. A leaf at level 0 has no such constraint.
- R10: A leaf needs A (bit 6). A store also needs D (bit 7). Otherwise the walk ends in a page fault.
- R11: A successful walk returns the leaf page number with its low L × index bits taken from the virtual page number, followed by the 12 page-offset bits of the virtual address.
- R12: `req_ready` is high only when no walk is in flight. `res_valid` and all result fields stay stable until `res_ready` is high. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is high.
- R13: `res_status` is 0, 1 or 2 only, and `res_type` equals the access type of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_levels | input | LVL_W | Table depth, 0 for no translation |
| cfg_idxbits | input | IDX_W | Index bits per level |
| cfg_pte8 | input | 1 | 1 for 8-byte entries, 0 for 4-byte |
| cfg_root_ppn | input | PPN_W | Page number of the root table |
| cfg_sum | input | 1 | Supervisor may touch user pages |
| cfg_mxr | input | 1 | Loads may read execute-only pages |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | XLEN | Virtual address |
| req_type | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Effective privilege, 1 = supervisor |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Entry read accepted |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_pmp_ok | input | 1 | Entry address passed the protection check |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_paddr | output | RES_W | Physical address (zero on fault) |
| res_status | output | 2 | 0 ok, 1 page fault, 2 access fault |
| res_type | output | 2 | Access type of the finished walk |

## Verification
The bench builds the walker with XLEN = 32, a 20-bit page number, at most 3 levels and at most 9 index bits. It drives 4 index bits and 2 levels at run time. Under these values the canonical boundary sits at bit 19. Both a zero-filled and a one-filled upper half are therefore legal addresses. A superpage at level 1 spans only 16 pages, so merging and misalignment show up with small tables. All tables fit a 256-word memory model. Running the same addresses with 4-byte entries and with a single level brings the entry-size scaling and the level-0 alignment exemption within reach.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_PAGE   = 2'd1,
    RES_ACCESS = 2'd2
  } res_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_READ,
    WS_WAIT,
    WS_DONE
  } wstate_e;

  localparam logic [1:0] PRIV_SUP = 2'd1;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;
  localparam int PPN_LSB = 10;
  localparam int PG_SHIFT = 12;
  localparam int PTE_W = 64;

endpackage

// File: rtl/pt_canon_check.sv
module pt_canon_check #(
  parameter int XLEN  = 64,
  parameter int LVL_W = 3,
  parameter int IDX_W = 4,
  parameter int SH_W  = 8
) (
  input  logic [XLEN-1:0]  vaddr,
  input  logic [LVL_W-1:0] levels,
  input  logic [IDX_W-1:0] idxbits,
  output logic             canon_ok
);
  localparam int XW = $clog2(XLEN);

  logic [SH_W-1:0] va_bits;
  logic [SH_W-1:0] top;
  logic            sign;

  always_comb begin
    va_bits  = SH_W'(12) + SH_W'(levels) * SH_W'(idxbits);
    top      = va_bits - SH_W'(1);
    sign     = vaddr[top[XW-1:0]];
    canon_ok = 1'b1;
    if (va_bits <= SH_W'(XLEN)) begin
      for (int i = 0; i < XLEN; i++) begin
        if ((SH_W'(i) >= top) && (vaddr[i] != sign)) canon_ok = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pt_pte_addr.sv
module pt_pte_addr #(
  parameter int XLEN    = 64,
  parameter int PA_W    = 56,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 4,
  parameter int MAX_IDX = 10,
  parameter int SH_W    = 8
) (
  input  logic [XLEN-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [IDX_W-1:0] idxbits,
  input  logic [PA_W-1:0]  base,
  input  logic             pte8,
  output logic [PA_W-1:0]  pte_addr
);
  logic [SH_W-1:0]    shift;
  logic [XLEN-1:0]    shifted;
  logic [MAX_IDX-1:0] idx_mask;
  logic [MAX_IDX-1:0] idx;

  always_comb begin
    shift    = SH_W'(12) + SH_W'(level) * SH_W'(idxbits);
    shifted  = vaddr >> shift;
    idx_mask = ~({MAX_IDX{1'b1}} << idxbits);
    idx      = shifted[MAX_IDX-1:0] & idx_mask;
    pte_addr = base + (PA_W'(idx) << (pte8 ? 3 : 2));
  end
endmodule

// File: rtl/pt_leaf_check.sv
module pt_leaf_check
  import pt_walker_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int PPN_W = 44,
  parameter int LVL_W = 3,
  parameter int IDX_W = 4,
  parameter int SH_W  = 8
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [XLEN-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [IDX_W-1:0] idxbits,
  input  logic [1:0]       acc,
  input  logic             smode,
  input  logic             sum,
  input  logic             mxr,
  output logic             is_ptr,
  output logic             fault,
  output logic [PPN_W-1:0] ppn,
  output logic [PPN_W-1:0] page
);
  logic [PPN_W-1:0] vpn_part;
  logic [PPN_W-1:0] low_mask;
  logic [SH_W-1:0]  sh;
  logic v, r, w, x, u, a, d;
  logic u_bad, enc_bad, perm_bad, align_bad, ad_bad;

  generate
    if (XLEN - PG_SHIFT >= PPN_W) begin : g_vpn_wide
      assign vpn_part = vaddr[PG_SHIFT +: PPN_W];
    end else begin : g_vpn_narrow
      assign vpn_part = {{(PPN_W - (XLEN - PG_SHIFT)){1'b0}}, vaddr[XLEN-1:PG_SHIFT]};
    end
  endgenerate

  always_comb begin
    v   = pte[BIT_V];
    r   = pte[BIT_R];
    w   = pte[BIT_W];
    x   = pte[BIT_X];
    u   = pte[BIT_U];
    a   = pte[BIT_A];
    d   = pte[BIT_D];
    ppn = pte[PPN_LSB +: PPN_W];
    sh  = SH_W'(level) * SH_W'(idxbits);
    low_mask = ~({PPN_W{1'b1}} << sh);

    is_ptr = v && !r && !w && !x;

    if (u) u_bad = smode && ((acc == ACC_FETCH) || !sum);
    else   u_bad = !smode;

    enc_bad = !v || (w && !r);

    unique case (acc)
      ACC_FETCH: perm_bad = !x;
      ACC_LOAD:  perm_bad = !(r || (mxr && x));
      default:   perm_bad = !(r && w);
    endcase

    align_bad = (ppn & low_mask) != '0;
    ad_bad    = !a || ((acc == ACC_STORE) && !d);

    fault = u_bad || enc_bad || perm_bad || align_bad || ad_bad;
    page  = (ppn & ~low_mask) | (vpn_part & low_mask);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int PPN_W   = 44,
  parameter int MAX_LVL = 5,
  parameter int MAX_IDX = 10,
  localparam int LVL_W  = $clog2(MAX_LVL + 1),
  localparam int IDX_W  = $clog2(MAX_IDX + 1),
  localparam int PA_W   = PPN_W + 12,
  localparam int RES_W  = (XLEN > PA_W) ? XLEN : PA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] cfg_levels,
  input  logic [IDX_W-1:0] cfg_idxbits,
  input  logic             cfg_pte8,
  input  logic [PPN_W-1:0] cfg_root_ppn,
  input  logic             cfg_sum,
  input  logic             cfg_mxr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [XLEN-1:0]  req_vaddr,
  input  logic [1:0]       req_type,
  input  logic [1:0]       req_priv,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  input  logic             mem_rsp_err,
  input  logic             mem_rsp_pmp_ok,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_paddr,
  output logic [1:0]       res_status,
  output logic [1:0]       res_type
);
  localparam int SH_RAW = 12 + MAX_LVL * MAX_IDX;
  localparam int SH_MAX = (SH_RAW > XLEN) ? SH_RAW : XLEN;
  localparam int SH_W   = $clog2(SH_MAX + 1) + 1;

  wstate_e          state_q;
  logic [XLEN-1:0]  va_q;
  logic [1:0]       type_q;
  logic             smode_q, sum_q, mxr_q, pte8_q;
  logic [IDX_W-1:0] idxb_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [RES_W-1:0] paddr_q;
  logic [1:0]       status_q;

  logic             canon_ok;
  logic [PA_W-1:0]  pte_addr;
  logic [PTE_W-1:0] pte;
  logic             is_ptr, leaf_fault;
  logic [PPN_W-1:0] ppn, page;
  logic             rsp_bad;

  pt_canon_check #(
    .XLEN(XLEN), .LVL_W(LVL_W), .IDX_W(IDX_W), .SH_W(SH_W)
  ) u_canon (
    .vaddr(req_vaddr), .levels(cfg_levels), .idxbits(cfg_idxbits), .canon_ok(canon_ok)
  );

  pt_pte_addr #(
    .XLEN(XLEN), .PA_W(PA_W), .LVL_W(LVL_W), .IDX_W(IDX_W),
    .MAX_IDX(MAX_IDX), .SH_W(SH_W)
  ) u_addr (
    .vaddr(va_q), .level(lvl_q), .idxbits(idxb_q), .base(base_q),
    .pte8(pte8_q), .pte_addr(pte_addr)
  );

  assign pte = pte8_q ? mem_rsp_data : {32'b0, mem_rsp_data[31:0]};

  pt_leaf_check #(
    .XLEN(XLEN), .PPN_W(PPN_W), .LVL_W(LVL_W), .IDX_W(IDX_W), .SH_W(SH_W)
  ) u_leaf (
    .pte(pte), .vaddr(va_q), .level(lvl_q), .idxbits(idxb_q), .acc(type_q),
    .smode(smode_q), .sum(sum_q), .mxr(mxr_q),
    .is_ptr(is_ptr), .fault(leaf_fault), .ppn(ppn), .page(page)
  );

  assign rsp_bad = mem_rsp_err || !mem_rsp_pmp_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WS_IDLE;
      va_q     <= '0;
      type_q   <= '0;
      smode_q  <= 1'b0;
      sum_q    <= 1'b0;
      mxr_q    <= 1'b0;
      pte8_q   <= 1'b0;
      idxb_q   <= '0;
      lvl_q    <= '0;
      base_q   <= '0;
      paddr_q  <= '0;
      status_q <= RES_OK;
    end else begin
      unique case (state_q)
        WS_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          type_q  <= req_type;
          smode_q <= (req_priv == PRIV_SUP);
          sum_q   <= cfg_sum;
          mxr_q   <= cfg_mxr;
          pte8_q  <= cfg_pte8;
          idxb_q  <= cfg_idxbits;
          lvl_q   <= cfg_levels - LVL_W'(1);
          base_q  <= {cfg_root_ppn, 12'b0};
          paddr_q <= '0;
          if (cfg_levels == '0) begin
            paddr_q  <= RES_W'(req_vaddr);
            status_q <= RES_OK;
            state_q  <= WS_DONE;
          end else if (!canon_ok) begin
            status_q <= RES_PAGE;
            state_q  <= WS_DONE;
          end else begin
            state_q  <= WS_READ;
          end
        end
        WS_READ: if (mem_req_ready) state_q <= WS_WAIT;
        WS_WAIT: if (mem_rsp_valid) begin
          if (rsp_bad) begin
            status_q <= RES_ACCESS;
            state_q  <= WS_DONE;
          end else if (is_ptr) begin
            if (lvl_q == '0) begin
              status_q <= RES_PAGE;
              state_q  <= WS_DONE;
            end else begin
              base_q  <= {ppn, 12'b0};
              lvl_q   <= lvl_q - LVL_W'(1);
              state_q <= WS_READ;
            end
          end else if (leaf_fault) begin
            status_q <= RES_PAGE;
            state_q  <= WS_DONE;
          end else begin
            paddr_q  <= RES_W'({page, va_q[11:0]});
            status_q <= RES_OK;
            state_q  <= WS_DONE;
          end
        end
        WS_DONE: if (res_ready) state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == WS_IDLE);
  assign mem_req_valid = (state_q == WS_READ);
  assign mem_req_addr  = pte_addr;
  assign res_valid     = (state_q == WS_DONE);
  assign res_paddr     = paddr_q;
  assign res_status    = status_q;
  assign res_type      = type_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 56,
  parameter int RES_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_err,
  input logic             mem_rsp_pmp_ok,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_paddr,
  input logic [1:0]       res_status,
  input logic [1:0]       res_type
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pend_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
    else if (mem_rsp_valid)               pend_q <= 1'b0;
  end

  // R12
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr)
                                && $stable(res_status) && $stable(res_type));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R12
  single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid && !pend_q);

  // R4
  access_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && mem_rsp_valid && (mem_rsp_err || !mem_rsp_pmp_ok)
      |=> res_valid && (res_status == 2'd2));

  // R13
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_status != 2'd3);

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_err(mem_rsp_err), .mem_rsp_pmp_ok(mem_rsp_pmp_ok),
  .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
  .res_status(res_status), .res_type(res_type)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  localparam int XLEN = 32, PPN_W = 20, MAX_LVL = 3, MAX_IDX = 9;
  localparam int LVL_W = 2, IDX_W = 4, PA_W = 32, RES_W = 32;

  localparam logic [1:0] A_F = 2'd0, A_L = 2'd1, A_S = 2'd2;
  localparam logic [1:0] P_U = 2'd0, P_S = 2'd1;
  localparam logic [1:0] S_OK = 2'd0, S_PF = 2'd1, S_AF = 2'd2;

  typedef struct packed {
    logic [1:0]  lv;
    logic        p8;
    logic [1:0]  ty;
    logic [1:0]  pv;
    logic        sm;
    logic        mx;
    logic [31:0] va;
    logic [1:0]  st;
    logic [31:0] pa;
    logic [2:0]  nr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00000123,S_OK,32'h000AB123,3'd2,4'd3},  // R3
    '{2'd2,1'b1,A_S,P_S,1'b0,1'b0,32'h00000456,S_OK,32'h000AB456,3'd2,4'd8},  // R8
    '{2'd2,1'b1,A_F,P_S,1'b0,1'b0,32'h00000010,S_PF,32'h0,3'd2,4'd8},         // R8
    '{2'd2,1'b1,A_F,P_S,1'b0,1'b0,32'h00001010,S_OK,32'h000C1010,3'd2,4'd8},  // R8
    '{2'd2,1'b1,A_S,P_S,1'b0,1'b0,32'h00001010,S_PF,32'h0,3'd2,4'd8},         // R8
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00002020,S_PF,32'h0,3'd2,4'd8},         // R8
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b1,32'h00002020,S_OK,32'h000C2020,3'd2,4'd8},  // R8
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00003000,S_PF,32'h0,3'd2,4'd7},         // R7
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00004000,S_PF,32'h0,3'd2,4'd6},         // R6
    '{2'd2,1'b1,A_L,P_S,1'b1,1'b0,32'h00004000,S_OK,32'h000C4000,3'd2,4'd6},  // R6
    '{2'd2,1'b1,A_F,P_S,1'b1,1'b0,32'h00004000,S_PF,32'h0,3'd2,4'd6},         // R6
    '{2'd2,1'b1,A_L,P_U,1'b0,1'b0,32'h00004000,S_OK,32'h000C4000,3'd2,4'd6},  // R6
    '{2'd2,1'b1,A_L,P_U,1'b0,1'b0,32'h00000000,S_PF,32'h0,3'd2,4'd6},         // R6
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00005000,S_PF,32'h0,3'd2,4'd10},        // R10
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00006000,S_OK,32'h000C6000,3'd2,4'd10}, // R10
    '{2'd2,1'b1,A_S,P_S,1'b0,1'b0,32'h00006000,S_PF,32'h0,3'd2,4'd10},        // R10
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00017ABC,S_OK,32'h00107ABC,3'd1,4'd11}, // R11
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00027000,S_PF,32'h0,3'd1,4'd9},         // R9
    '{2'd1,1'b1,A_L,P_S,1'b0,1'b0,32'h00002345,S_OK,32'h00101345,3'd1,4'd9},  // R9
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00030000,S_PF,32'h0,3'd1,4'd7},         // R7
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00040000,S_PF,32'h0,3'd2,4'd5},         // R5
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00050000,S_AF,32'h0,3'd2,4'd4},         // R4
    '{2'd2,1'b1,A_S,P_S,1'b0,1'b0,32'h00060000,S_AF,32'h0,3'd2,4'd4},         // R4
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h80000000,S_PF,32'h0,3'd0,4'd2},         // R2
    '{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'hFFF80123,S_OK,32'h000AB123,3'd2,4'd2},  // R2
    '{2'd0,1'b1,A_S,P_S,1'b0,1'b0,32'hDEADBEEF,S_OK,32'hDEADBEEF,3'd0,4'd1},  // R1
    '{2'd2,1'b0,A_L,P_S,1'b0,1'b0,32'h00000123,S_OK,32'h000AB123,3'd2,4'd3}   // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LVL_W-1:0] cfg_levels = '0;
  logic [IDX_W-1:0] cfg_idxbits = 4'd4;
  logic cfg_pte8 = 1'b1, cfg_sum = 1'b0, cfg_mxr = 1'b0;
  logic [PPN_W-1:0] cfg_root_ppn = 20'h1;
  logic req_valid = 1'b0, req_ready;
  logic [XLEN-1:0] req_vaddr = '0;
  logic [1:0] req_type = '0, req_priv = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [PA_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0, mem_rsp_pmp_ok = 1'b1;
  logic [63:0] mem_rsp_data = '0;
  logic res_valid, res_ready = 1'b0;
  logic [RES_W-1:0] res_paddr;
  logic [1:0] res_status, res_type;

  int n_chk = 0, n_bad = 0;
  int rd_total = 0, rs = 0;
  logic [31:0] lat;
  logic [31:0] addr_hist [16];
  logic [63:0] mem [256];
  int rd_start;
  logic [31:0] got_pa, got_first;
  logic [1:0] got_st, got_ty;

  always #2.5 clk = ~clk;

  pt_walker #(.XLEN(XLEN), .PPN_W(PPN_W), .MAX_LVL(MAX_LVL), .MAX_IDX(MAX_IDX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_levels(cfg_levels), .cfg_idxbits(cfg_idxbits),
    .cfg_pte8(cfg_pte8), .cfg_root_ppn(cfg_root_ppn), .cfg_sum(cfg_sum), .cfg_mxr(cfg_mxr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_type(req_type), .req_priv(req_priv),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_pmp_ok(mem_rsp_pmp_ok), .res_valid(res_valid), .res_ready(res_ready),
    .res_paddr(res_paddr), .res_status(res_status), .res_type(res_type)
  );

  // Memory model: page 5 fails protection, page 6 returns an error.
  always @(negedge clk) begin
    case (rs)
      0: if (rst_n && mem_req_valid) begin
        mem_req_ready = 1'b1;
        lat = mem_req_addr;
        addr_hist[rd_total % 16] = lat;
        rd_total = rd_total + 1;
        rs = 1;
      end
      1: begin
        mem_req_ready  = 1'b0;
        mem_rsp_valid  = 1'b1;
        mem_rsp_data   = mem[{lat[15:12], cfg_pte8 ? lat[6:3] : lat[5:2]}];
        mem_rsp_err    = (lat[15:12] == 4'h6);
        mem_rsp_pmp_ok = (lat[15:12] != 4'h5);
        rs = 2;
      end
      default: begin
        mem_rsp_valid  = 1'b0;
        mem_rsp_err    = 1'b0;
        mem_rsp_pmp_ok = 1'b1;
        rs = 0;
      end
    endcase
  end

  function automatic logic [63:0] mk(input logic [19:0] ppn, input logic [7:0] fl);
    return (64'(ppn) << 10) | 64'(fl);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    cfg_levels = v.lv; cfg_pte8 = v.p8; req_type = v.ty; req_priv = v.pv;
    cfg_sum = v.sm; cfg_mxr = v.mx; req_vaddr = v.va;
    rd_start = rd_total;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 500 && !res_valid; n++) @(negedge clk);
    got_pa = res_paddr; got_st = res_status; got_ty = res_type;
    got_first = addr_hist[rd_start % 16];
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h10] = mk(20'h2, 8'h01);
    mem[8'h11] = mk(20'h100, 8'hCF);
    mem[8'h12] = mk(20'h101, 8'hCF);
    mem[8'h14] = mk(20'h3, 8'h01);
    mem[8'h15] = mk(20'h5, 8'h01);
    mem[8'h16] = mk(20'h6, 8'h01);
    mem[8'h18] = mk(20'h2, 8'h01);
    mem[8'h20] = mk(20'hAB, 8'hC7);
    mem[8'h21] = mk(20'hC1, 8'h4B);
    mem[8'h22] = mk(20'hC2, 8'h49);
    mem[8'h23] = mk(20'hC3, 8'hC5);
    mem[8'h24] = mk(20'hC4, 8'hDF);
    mem[8'h25] = mk(20'hC5, 8'h07);
    mem[8'h26] = mk(20'hC6, 8'h47);
    mem[8'h30] = mk(20'h2, 8'h01);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R12", "reset req_ready", 64'(req_ready), 64'd1);
    check(res_valid == 1'b0, "R12", "reset res_valid", 64'(res_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R12", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);

    for (int k = 0; k < NV; k++) begin
      run_vec(TBL[k]);
      check(got_st == TBL[k].st, $sformatf("R%0d", TBL[k].rq), $sformatf("status v%0d", k),
            64'(got_st), 64'(TBL[k].st));
      check(got_ty == TBL[k].ty, "R13", $sformatf("type v%0d", k), 64'(got_ty), 64'(TBL[k].ty));
      check(got_pa == TBL[k].pa, $sformatf("R%0d", TBL[k].rq), $sformatf("paddr v%0d", k),
            64'(got_pa), 64'(TBL[k].pa));
      check((rd_total - rd_start) == int'(TBL[k].nr), $sformatf("R%0d", TBL[k].rq),
            $sformatf("reads v%0d", k), 64'(rd_total - rd_start), 64'(TBL[k].nr));
    end

    // R3: entry size scales the root index (idx 1 -> +8 or +4)
    run_vec('{2'd2,1'b1,A_L,P_S,1'b0,1'b0,32'h00010000,S_OK,32'h00100000,3'd1,4'd3});
    check(got_first == 32'h1008, "R3", "first addr pte8", 64'(got_first), 64'h1008);
    check(got_pa == 32'h00100000, "R11", "superpage base", 64'(got_pa), 64'h100000);
    run_vec('{2'd2,1'b0,A_L,P_S,1'b0,1'b0,32'h00010000,S_OK,32'h00100000,3'd1,4'd3});
    check(got_first == 32'h1004, "R3", "first addr pte4", 64'(got_first), 64'h1004);

    // R12: busy walker refuses requests, result held under back-pressure
    @(negedge clk);
    cfg_levels = 2'd2; cfg_pte8 = 1'b1; req_type = A_L; req_priv = P_S;
    cfg_sum = 1'b0; cfg_mxr = 1'b0; req_vaddr = 32'h00000777;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R12", "busy req_ready", 64'(req_ready), 64'd0);
    for (int n = 0; n < 500 && !res_valid; n++) @(negedge clk);
    got_pa = res_paddr;
    check(got_pa == 32'h000AB777, "R12", "held paddr", 64'(got_pa), 64'hAB777);
    repeat (4) @(negedge clk);
    check(res_valid == 1'b1, "R12", "valid held", 64'(res_valid), 64'd1);
    check(res_paddr == got_pa, "R12", "paddr stable", 64'(res_paddr), 64'(got_pa));
    check(req_ready == 1'b0, "R12", "no accept while result pending", 64'(req_ready), 64'd0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(res_valid == 1'b0 && req_ready == 1'b1, "R12", "drained",
          64'({res_valid, req_ready}), 64'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule